// File: doc/BRIEF.md
# Constant-Time Ciphertext Compare and Secret Selector

This block is the last step of a key-decapsulation datapath. Once a ciphertext has been re-derived from the decrypted message, the block reads the re-derived copy and the received copy out of two byte memories at the same address. It folds every byte difference into one sticky flag. When the final byte has been seen, it latches a reject decision and uses it to choose one of two 256-bit secrets: the candidate key or the rejection key.

The walk never stops early. It always covers the full ciphertext length set by the security level. A run therefore takes the same number of cycles whether the copies match, differ in their first byte or differ only in their last byte. The selection is a mux that is always present, not a status bit that software reads.

When the block is started for any operation other than decapsulation, the compare still runs to completion but the reject flag stays 0. The candidate key then appears on the output unchanged.

Top module: `ct_reject_select`

## Requirements
- R1: The level input sets the walk length: code 0 gives 768 bytes, code 1 gives 1088 bytes, and codes 2 and 3 give 1568 bytes. The read address goes through 0, 1, ... up to length-1, one step per cycle, each address exactly once.
- R2: A single read address is shared by both byte memories. Each memory returns its byte one cycle after the address is presented.
- R3: In decapsulation mode, a difference of even one bit in any byte (first, middle or last) sets the reject output to 1 at the end of the run.
- R4: When both copies are equal over the whole length, the reject output is 0 at the end of the run.
- R5: The done output is high for exactly one cycle. It rises length+1 clock edges after the edge that accepts start. This count does not depend on the data.
- R6: The output key equals the rejection key while reject is 1, and equals the candidate key while reject is 0.
- R7: When the decapsulation input is low at start, reject ends at 0 even if the copies differ, so the candidate key passes through.
- R8: An accepted start clears reject. A start pulse that arrives while a run is in progress is ignored and does not change that run's length or result.
- R9: After reset, busy, done and reject are 0 and the read address is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a compare (accepted only when idle) |
| level_i | input | 2 | Security-level code that sets the length |
| decap_i | input | 1 | 1 = decapsulation, which allows reject to be set |
| rd_addr_o | output | 11 | Byte address shared by both memories |
| recomp_byte_i | input | 8 | Byte read from the re-derived ciphertext memory |
| recv_byte_i | input | 8 | Byte read from the received ciphertext memory |
| cand_key_i | input | 256 | Candidate shared secret |
| rej_key_i | input | 256 | Rejection secret |
| busy_o | output | 1 | An address walk is in progress |
| done_o | output | 1 | One-cycle pulse marking the end of a compare |
| reject_o | output | 1 | Latched mismatch decision |
| key_o | output | 256 | Selected secret |

## Verification
The start is accepted at one clock edge, which counts as edge zero. After that edge the address steps forward once per edge and busy stays high for exactly length cycles. The byte for each address comes back one edge later. Reject and done both update at edge length+1, and done falls again at the next edge. The bench drives its inputs and samples the outputs on falling edges. It counts rising edges from the accepting edge until done is seen, and checks that the count is length+1 for every data pattern and level. It reads reject and the output key in that same done cycle, then checks that done has fallen one cycle later.

// File: rtl/ct_sel_pkg.sv
package ct_sel_pkg;

    // Token handed from the address walker to the compare stage, one cycle later
    typedef struct packed {
        logic vld;
        logic last;
        logic decap;
    } tok_t;

endpackage

// File: rtl/ct_sel_walker.sv
module ct_sel_walker
    import ct_sel_pkg::*;
#(
    parameter int LEN_A = 768,
    parameter int LEN_B = 1088,
    parameter int LEN_C = 1568,
    localparam int AW = $clog2(LEN_C)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic [1:0]    level_i,
    input  logic          decap_i,
    output logic [AW-1:0] rd_addr_o,
    output logic          busy_o,
    output logic          idle_o,
    output tok_t          tok_o
);
    localparam logic [AW-1:0] LIM_A = AW'(LEN_A - 1);
    localparam logic [AW-1:0] LIM_B = AW'(LEN_B - 1);
    localparam logic [AW-1:0] LIM_C = AW'(LEN_C - 1);

    typedef struct packed {
        logic          busy;
        logic [AW-1:0] idx;
        logic [AW-1:0] lim;
        logic          decap;
        tok_t          tok;
    } walk_t;

    walk_t st_d, st_q;
    logic [AW-1:0] lim_sel;

    always_comb begin
        unique case (level_i)
            2'd0:    lim_sel = LIM_A;
            2'd1:    lim_sel = LIM_B;
            default: lim_sel = LIM_C;
        endcase
    end

    always_comb begin
        st_d     = st_q;
        st_d.tok = '0;
        if (st_q.busy) begin
            st_d.tok.vld   = 1'b1;
            st_d.tok.last  = (st_q.idx == st_q.lim);
            st_d.tok.decap = st_q.decap;
            if (st_q.idx == st_q.lim) begin
                st_d.busy = 1'b0;
                st_d.idx  = '0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end else if (start_i && !st_q.tok.vld) begin
            st_d.busy  = 1'b1;
            st_d.idx   = '0;
            st_d.lim   = lim_sel;
            st_d.decap = decap_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rd_addr_o = st_q.idx;
    assign busy_o    = st_q.busy;
    assign idle_o    = !st_q.busy && !st_q.tok.vld;
    assign tok_o     = st_q.tok;
endmodule

// File: rtl/ct_sel_accum.sv
module ct_sel_accum
    import ct_sel_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       clr_i,
    input  tok_t       tok_i,
    input  logic [7:0] byte_a_i,
    input  logic [7:0] byte_b_i,
    output logic       reject_o,
    output logic       done_o
);
    typedef struct packed {
        logic acc;
        logic reject;
        logic done;
    } acc_t;

    acc_t st_d, st_q;
    logic diff_now;

    assign diff_now = |(byte_a_i ^ byte_b_i);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (clr_i) begin
            st_d.acc    = 1'b0;
            st_d.reject = 1'b0;
        end else if (tok_i.vld) begin
            st_d.acc = st_q.acc | diff_now;
            if (tok_i.last) begin
                st_d.reject = (st_q.acc | diff_now) & tok_i.decap;
                st_d.done   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign reject_o = st_q.reject;
    assign done_o   = st_q.done;
endmodule

// File: rtl/ct_sel_keymux.sv
module ct_sel_keymux #(
    parameter int KEY_W = 256,
    localparam int LANES = KEY_W / 8
) (
    input  logic             sel_i,
    input  logic [KEY_W-1:0] cand_i,
    input  logic [KEY_W-1:0] rej_i,
    output logic [KEY_W-1:0] key_o
);
    // Per-byte lanes, each driven by a full-width select mask
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] m_w;
        assign m_w = {8{sel_i}};
        assign key_o[g*8 +: 8] = (rej_i[g*8 +: 8] & m_w) | (cand_i[g*8 +: 8] & ~m_w);
    end
endmodule

// File: rtl/ct_reject_select.sv
module ct_reject_select
    import ct_sel_pkg::*;
#(
    parameter int KEY_W = 256,
    parameter int LEN_A = 768,
    parameter int LEN_B = 1088,
    parameter int LEN_C = 1568,
    localparam int AW = $clog2(LEN_C)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [1:0]       level_i,
    input  logic             decap_i,
    output logic [AW-1:0]    rd_addr_o,
    input  logic [7:0]       recomp_byte_i,
    input  logic [7:0]       recv_byte_i,
    input  logic [KEY_W-1:0] cand_key_i,
    input  logic [KEY_W-1:0] rej_key_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             reject_o,
    output logic [KEY_W-1:0] key_o
);
    tok_t tok_w;
    logic idle_w;

    ct_sel_walker #(.LEN_A(LEN_A), .LEN_B(LEN_B), .LEN_C(LEN_C)) walk_i (
        .clk_i, .rst_ni, .start_i, .level_i, .decap_i,
        .rd_addr_o, .busy_o, .idle_o(idle_w), .tok_o(tok_w)
    );

    ct_sel_accum acc_i (
        .clk_i, .rst_ni,
        .clr_i   (start_i && idle_w),
        .tok_i   (tok_w),
        .byte_a_i(recomp_byte_i),
        .byte_b_i(recv_byte_i),
        .reject_o, .done_o
    );

    ct_sel_keymux #(.KEY_W(KEY_W)) mux_i (
        .sel_i (reject_o),
        .cand_i(cand_key_i),
        .rej_i (rej_key_i),
        .key_o
    );
endmodule

// File: rtl/ct_reject_select_chk.sv
module ct_reject_select_chk #(
    parameter int KEY_W = 256,
    parameter int AW = 11,
    parameter int LEN_C = 1568
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             busy_o,
    input logic             done_o,
    input logic             reject_o,
    input logic [AW-1:0]    rd_addr_o,
    input logic [KEY_W-1:0] cand_key_i,
    input logic [KEY_W-1:0] rej_key_i,
    input logic [KEY_W-1:0] key_o
);
    // R5: done lasts a single cycle
    assert_done_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R8: a fresh walk begins with reject cleared
    assert_start_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> !reject_o);

    // R3: reject can only rise together with the done pulse
    assert_reject_at_end_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(reject_o) |-> done_o);

    // R1: the address stays inside the longest array
    assert_addr_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> (int'(rd_addr_o) < LEN_C));

    // R1: the address only ever steps up by one while a walk continues
    assert_addr_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o && $past(busy_o) |-> rd_addr_o == $past(rd_addr_o) + 1'b1);

    // R6: the output key follows the latched decision
    assert_key_select_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        key_o == (reject_o ? rej_key_i : cand_key_i));
endmodule

bind ct_reject_select ct_reject_select_chk #(.KEY_W(KEY_W), .AW(AW), .LEN_C(LEN_C)) chk_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
    .reject_o(reject_o), .rd_addr_o(rd_addr_o), .cand_key_i(cand_key_i),
    .rej_key_i(rej_key_i), .key_o(key_o)
);

// File: tb/ct_reject_select_tb_top.sv
module ct_reject_select_tb_top;
    localparam int KW = 256;
    localparam int AW = 11;
    localparam int MAXL = 1568;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    level = 2'd0;
    logic          decap = 1'b1;
    logic [AW-1:0] addr;
    logic [7:0]    ra, rb;
    logic [KW-1:0] cand, rej, key;
    logic          busy, done, reject;

    logic [7:0] mem_a [0:MAXL-1];
    logic [7:0] mem_b [0:MAXL-1];

    int n_chk = 0, n_bad = 0;
    int cyc = 0;
    int busy_cnt = 0, order_bad = 0;

    always #10 clk = ~clk;

    ct_reject_select dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .level_i(level),
        .decap_i(decap), .rd_addr_o(addr), .recomp_byte_i(ra),
        .recv_byte_i(rb), .cand_key_i(cand), .rej_key_i(rej),
        .busy_o(busy), .done_o(done), .reject_o(reject), .key_o(key)
    );

    // Byte memories: registered read, one cycle after the address
    always_ff @(posedge clk) begin
        ra <= mem_a[addr];
        rb <= mem_b[addr];
    end

    // Address monitor, sampled on the falling edge
    always @(negedge clk) begin
        if (busy) begin
            if (int'(addr) != busy_cnt) order_bad++;
            busy_cnt++;
        end
    end

    // Watchdog: counts as a failed check and still prints the summary
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles, expected < 150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int len_of(input int lv);
        return (lv == 0) ? 768 : (lv == 1) ? 1088 : 1568;
    endfunction

    // pat: 0 equal, 1 diff first, 2 diff middle, 3 diff last
    task automatic run(input int lv, input int pat, input logic dc, input bit mid_start);
        int len, n, exp_rej;
        len = len_of(lv);
        for (int i = 0; i < MAXL; i++) begin
            mem_a[i] = 8'((i * 37 + lv * 11 + pat) & 8'hFF);
            mem_b[i] = mem_a[i];
        end
        if (pat == 1) mem_b[0]       = mem_b[0] ^ 8'h01;
        if (pat == 2) mem_b[len / 2] = mem_b[len / 2] ^ 8'h10;
        if (pat == 3) mem_b[len - 1] = mem_b[len - 1] ^ 8'h80;
        // bytes past the length differ: must not affect the result
        mem_b[MAXL - 1] = mem_a[MAXL - 1] ^ ((lv < 2) ? 8'hFF : 8'h00) ^ ((pat == 3 && lv >= 2) ? 8'h80 : 8'h00);
        cand = {8{32'hC0DE0000 + 32'(lv * 16 + pat)}};
        rej  = {8{32'h5EC00000 + 32'(lv * 16 + pat)}};
        exp_rej = (dc && pat != 0) ? 1 : 0;

        @(negedge clk);
        busy_cnt = 0; order_bad = 0;
        level = 2'(lv); decap = dc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        level = 2'(3 - lv); decap = ~dc;  // later input changes must not matter
        check("R8 reject cleared after start", reject, 0);
        n = 0;
        while (!done && n < 3000) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (mid_start && n == 10) start = 1'b1;
            else start = 1'b0;
        end
        start = 1'b0;
        check($sformatf("R5 latency lv%0d pat%0d", lv, pat), n, len + 1);
        check($sformatf("R1 address count lv%0d", lv), busy_cnt, len);
        check("R1 address order", order_bad, 0);
        if (!dc) check("R7 non-decap reject", reject, 0);
        else if (pat == 0) check("R4 equal reject", reject, 0);
        else check($sformatf("R3 diff reject pat%0d", pat), reject, 1);
        check("R6 key select", (key == (exp_rej ? rej : cand)) ? 1 : 0, 1);
        @(negedge clk);
        check("R5 done single cycle", done, 0);
        check("R2 R6 key held after done", (key == (exp_rej ? rej : cand)) ? 1 : 0, 1);
        if (mid_start) check("R8 mid-run start ignored", busy, 0);
    endtask

    initial begin
        for (int i = 0; i < MAXL; i++) begin mem_a[i] = 8'h0; mem_b[i] = 8'h0; end
        cand = '0; rej = '1;
        repeat (3) @(negedge clk);
        check("R9 reset busy", busy, 0);
        check("R9 reset done", done, 0);
        check("R9 reset reject", reject, 0);
        check("R9 reset addr", addr, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int lv = 0; lv < 4; lv++)
            for (int pat = 0; pat < 4; pat++)
                run(lv, pat, 1'b1, 1'b0);
        for (int lv = 0; lv < 3; lv++) run(lv, 3, 1'b0, 1'b0);
        run(1, 2, 1'b1, 1'b1);
        run(0, 0, 1'b1, 1'b1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule